// File: doc/BRIEF.md
# Random Number Generator Controller

This block is a register-mapped front end for a random number source. A host talks to it over a simple single-cycle 32-bit bus with a 12-bit byte address. Reads are combinational: the read data for the presented address is valid in the same cycle. Writes take effect at the next rising clock edge. The bus is always ready and has no back-pressure, so every access completes in the cycle it is presented.

Two maintenance operations, seeding and self-test, each move from idle to running to done. Each takes a fixed, parameterised number of cycles to finish. The progress of both operations is visible through the command and status words. A completion raises a level interrupt unless completion interrupts are masked.

Random words come from an internal 32-bit linear feedback shift register. Each read of the data port returns the current value and then advances the register by one step. The status word reports an always-full output store and never reports an error.

Top module: `rngc_top`

## Requirements
- R1: Reads decode the full byte address: 0x000 version, 0x004 command, 0x008 control, 0x00C status, 0x014 data. Every other address, including misaligned ones, reads 0x00000000. The version word is 0x10000240. Writes to version, status, data or unmapped addresses change nothing.
- R2: A write to command with bit 1 set starts seeding, and with bit 0 set starts self-test. Both may be set in one write. A command read returns bit 1 = seeding running and bit 0 = self-test running, with all other bits 0.
- R3: A started operation stays running for exactly OP_CYCLES clock cycles (default 16), counted from the write edge, and then becomes done. Starting an operation that is already running restarts its full count.
- R4: The status word reads 5 in bits 15:12, 5 in bits 11:8 and 1 in bit 6. Bit 5 = seed done and bit 4 = self-test done. Bit 1 (busy) = either operation running; bit 0 (ready) = not busy. All other bits read 0. After reset the status word is 0x00005541.
- R5: When an operation becomes done, output irq goes high at that same edge, provided control bit 5 (mask done) is 0. Once high, irq stays high until it is cleared or reset.
- R6: A command write with bit 4 or bit 5 set drops irq. If a completion occurs at the same edge as the clear, irq stays high.
- R7: Control bits 6 (mask error), 5 (mask done) and 4 (auto-seed) read back as written. All other control bits read 0.
- R8: A command write with bit 6 set (soft reset) and the hardware reset rst_n both return both operations to idle, clear control and drop irq. A soft reset aborts a running operation without raising irq. Start bits in the same write as a soft reset take effect after the reset.
- R9: Each data port read returns the generator value, and the generator advances one step at that edge. The step is a Galois right shift with feedback mask 0x80200003, applied when the bit shifted out is 1. The value after rst_n is 0x6A09E667, and the value is never zero. Soft reset does not reseed the generator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level completion interrupt |

## Verification
Two events can fall on the same clock edge: an operation finishing and a command write that clears the interrupt, or a soft reset combined with start bits. The bench counts cycles from the start write so that the clear write lands exactly on the completion edge, and it requires irq to stay high afterwards. It also issues a combined reset-and-start write while an operation is done, and requires the command word to show the new operation running with control cleared.

// File: rtl/rngc_pkg.sv
package rngc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RUN  = 2'd1,
    OP_DONE = 2'd2
  } op_state_e;

  localparam logic [11:0] ADR_VERSION = 12'h000;
  localparam logic [11:0] ADR_COMMAND = 12'h004;
  localparam logic [11:0] ADR_CONTROL = 12'h008;
  localparam logic [11:0] ADR_STATUS  = 12'h00C;
  localparam logic [11:0] ADR_DATA    = 12'h014;

  localparam int CMD_SRST  = 6;
  localparam int CMD_CLRE  = 5;
  localparam int CMD_CLRI  = 4;
  localparam int CMD_SEED  = 1;
  localparam int CMD_STEST = 0;

  localparam int CTL_MERR  = 6;
  localparam int CTL_MDONE = 5;
  localparam int CTL_AUTO  = 4;

  localparam logic [31:0] VERSION_WORD = 32'h1000_0240;
endpackage

// File: rtl/rngc_op_fsm.sv
module rngc_op_fsm
  import rngc_pkg::*;
#(
  parameter int OP_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic start,
  output logic running,
  output logic done,
  output logic finish
);
  localparam int CNT_W = $clog2(OP_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(OP_CYCLES - 1);

  op_state_e        state;
  logic [CNT_W-1:0] cnt;

  assign running = (state == OP_RUN);
  assign done    = (state == OP_DONE);
  assign finish  = running && (cnt == '0) && !start && !soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= OP_IDLE;
      cnt   <= '0;
    end else if (start) begin
      state <= OP_RUN;
      cnt   <= CNT_LOAD;
    end else if (soft_rst) begin
      state <= OP_IDLE;
      cnt   <= '0;
    end else if (running) begin
      if (cnt == '0) state <= OP_DONE;
      else           cnt   <= cnt - 1'b1;
    end
  end

  assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> running);
  assert_done_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start && !soft_rst) |=> done);
  assert_srst_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !start) |=> (!running && !done));
endmodule

// File: rtl/rngc_lfsr.sv
module rngc_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = 32'h8020_0003,
  parameter logic [W-1:0] SEED = 32'h6A09_E667
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] value
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = value >> 1;
    if (value[0]) nxt = nxt ^ TAPS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= SEED;
    else if (adv) value <= nxt;
  end

  assert_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    value != '0);
  assert_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (value != $past(value)));
endmodule

// File: rtl/rngc_top.sv
module rngc_top
  import rngc_pkg::*;
#(
  parameter int OP_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int NOPS = 2;  // index 0 = self-test, 1 = seed

  logic wr_cmd, wr_ctl, rd_data, soft_rst, clr_irq;
  logic mask_err, mask_done, auto_seed;
  logic [NOPS-1:0] op_start, op_run, op_done, op_fin;
  logic [31:0] lfsr_val;

  assign wr_cmd   = bus_sel && bus_wr && (bus_addr == ADR_COMMAND);
  assign wr_ctl   = bus_sel && bus_wr && (bus_addr == ADR_CONTROL);
  assign rd_data  = bus_sel && !bus_wr && (bus_addr == ADR_DATA);
  assign soft_rst = wr_cmd && bus_wdata[CMD_SRST];
  assign clr_irq  = wr_cmd && (bus_wdata[CMD_CLRE] || bus_wdata[CMD_CLRI]);
  assign op_start[0] = wr_cmd && bus_wdata[CMD_STEST];
  assign op_start[1] = wr_cmd && bus_wdata[CMD_SEED];

  generate
    for (genvar g = 0; g < NOPS; g++) begin : g_op
      rngc_op_fsm #(.OP_CYCLES(OP_CYCLES)) op_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst),
        .start   (op_start[g]),
        .running (op_run[g]),
        .done    (op_done[g]),
        .finish  (op_fin[g])
      );
    end
  endgenerate

  rngc_lfsr u_lfsr (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (rd_data),
    .value(lfsr_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_err  <= 1'b0;
      mask_done <= 1'b0;
      auto_seed <= 1'b0;
    end else if (soft_rst) begin
      mask_err  <= 1'b0;
      mask_done <= 1'b0;
      auto_seed <= 1'b0;
    end else if (wr_ctl) begin
      mask_err  <= bus_wdata[CTL_MERR];
      mask_done <= bus_wdata[CTL_MDONE];
      auto_seed <= bus_wdata[CTL_AUTO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        irq <= 1'b0;
    else if (soft_rst)                 irq <= 1'b0;
    else if ((|op_fin) && !mask_done)  irq <= 1'b1;
    else if (clr_irq)                  irq <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADR_VERSION: bus_rdata = VERSION_WORD;
      ADR_COMMAND: bus_rdata = {30'd0, op_run[1], op_run[0]};
      ADR_CONTROL: bus_rdata = {25'd0, mask_err, mask_done, auto_seed, 4'd0};
      ADR_STATUS:  bus_rdata = {16'd0, 4'd5, 4'd5, 1'b0, 1'b1, op_done[1],
                                op_done[0], 2'b00, |op_run, ~(|op_run)};
      ADR_DATA:    bus_rdata = lfsr_val;
      default:     bus_rdata = '0;
    endcase
  end

  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ((op_done[0] && !$past(op_done[0])) ||
                    (op_done[1] && !$past(op_done[1]))));
  assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_irq && !(|op_fin)) |=> !irq);
  assert_srst_ctl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!mask_err && !mask_done && !auto_seed && !irq));
endmodule

// File: tb/rngc_top_tb.sv
module rngc_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam logic [31:0] SEED = 32'h6A09_E667;
  localparam logic [31:0] TAPS = 32'h8020_0003;
  localparam logic [11:0] A_VER = 12'h000, A_CMD = 12'h004, A_CTL = 12'h008,
                          A_STS = 12'h00C, A_DAT = 12'h014;

  // {is_write, addr, wdata, expected read}
  localparam int NV = 12;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, A_VER,   32'h0, 32'h1000_0240},
    {1'b0, 12'h010, 32'h0, 32'h0},
    {1'b0, 12'h018, 32'h0, 32'h0},
    {1'b0, 12'hFFC, 32'h0, 32'h0},
    {1'b0, 12'h001, 32'h0, 32'h0},
    {1'b1, A_VER,   32'hFFFF_FFFF, 32'h0},
    {1'b0, A_VER,   32'h0, 32'h1000_0240},
    {1'b1, A_CTL,   32'hFFFF_FFFF, 32'h0},
    {1'b0, A_CTL,   32'h0, 32'h0000_0070},
    {1'b1, A_CTL,   32'h0000_0010, 32'h0},
    {1'b0, A_CTL,   32'h0, 32'h0000_0010},
    {1'b0, A_STS,   32'h0, 32'h0000_5541}
  };

  logic clk = 0, rst_n = 0, bus_sel = 0, bus_wr = 0, irq;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int checks = 0, fails = 0;
  logic [31:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  rngc_top #(.OP_CYCLES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic rd_data(output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = A_DAT; #1; d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  function automatic logic [31:0] step(input logic [31:0] v);
    return v[0] ? ((v >> 1) ^ TAPS) : (v >> 1);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    cyc(2); rst_n = 1; cyc(1);
    // reset state R4 R7 R5
    peek(A_STS, r); chk("R4 reset status", r, 32'h5541);
    peek(A_CMD, r); chk("R2 reset command", r, 0);
    peek(A_CTL, r); chk("R7 reset control", r, 0);
    chk("R5 reset irq", {31'd0, irq}, 0);

    // vector table: R1 R7 R4
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32]);
      else begin peek(VEC[i][75:64], r); chk("R1/R7 vector", r, VEC[i][31:0]); end
    end
    wr(A_CTL, 0);

    // seed run R2 R3 R4 R5
    wr(A_CMD, 32'h2);
    peek(A_CMD, r); chk("R2 seed running", r, 32'h2);
    peek(A_STS, r); chk("R4 busy", r, 32'h5542);
    cyc(N-1);
    peek(A_CMD, r); chk("R3 still running at N-1", r, 32'h2);
    cyc(1);
    peek(A_STS, r); chk("R3 seed done", r, 32'h5561);
    chk("R5 irq on done", {31'd0, irq}, 1);
    cyc(5);
    chk("R5 irq level held", {31'd0, irq}, 1);
    wr(A_CMD, 32'h10);
    chk("R6 clear via bit4", {31'd0, irq}, 0);
    peek(A_STS, r); chk("R6 done kept after clear", r, 32'h5561);

    // masked self-test R5
    wr(A_CTL, 32'h20);
    wr(A_CMD, 32'h1);
    peek(A_CMD, r); chk("R2 self-test running", r, 32'h1);
    cyc(N);
    peek(A_STS, r); chk("R3 self-test done", r, 32'h5571);
    chk("R5 masked no irq", {31'd0, irq}, 0);
    wr(A_CTL, 0);

    // clear via bit5, both in one write R2 R6
    wr(A_CMD, 32'h3);
    peek(A_CMD, r); chk("R2 both running", r, 32'h3);
    cyc(N);
    chk("R5 irq after both", {31'd0, irq}, 1);
    wr(A_CMD, 32'h20);
    chk("R6 clear via bit5", {31'd0, irq}, 0);

    // restart R3
    wr(A_CMD, 32'h2);
    cyc(10);
    wr(A_CMD, 32'h2);
    cyc(N-1);
    peek(A_CMD, r); chk("R3 restart extends run", r, 32'h2);
    cyc(1);
    peek(A_CMD, r); chk("R3 restart then done", r, 0);
    wr(A_CMD, 32'h10);

    // completion coincides with clear R6
    wr(A_CMD, 32'h1);
    cyc(N-1);
    wr(A_CMD, 32'h10);
    chk("R6 completion beats clear", {31'd0, irq}, 1);

    // soft reset R8
    wr(A_CTL, 32'h70);
    wr(A_CMD, 32'h40);
    chk("R8 srst irq", {31'd0, irq}, 0);
    peek(A_CTL, r); chk("R8 srst control", r, 0);
    peek(A_STS, r); chk("R8 srst status", r, 32'h5541);
    // reset plus start in one write
    wr(A_CMD, 32'h2); cyc(N);
    wr(A_CTL, 32'h10);
    wr(A_CMD, 32'h42);
    peek(A_CMD, r); chk("R8 srst then start", r, 32'h2);
    peek(A_CTL, r); chk("R8 srst+start control", r, 0);
    cyc(3);
    wr(A_CMD, 32'h40);
    cyc(N + 2);
    chk("R8 abort no irq", {31'd0, irq}, 0);
    peek(A_STS, r); chk("R8 abort idle", r, 32'h5541);

    // generator R9
    model = SEED;
    for (int i = 0; i < 6; i++) begin
      rd_data(r); chk("R9 data word", r, model);
      model = step(model);
    end
    peek(A_DAT, r); chk("R9 peek does not advance", r, model);
    wr(A_CMD, 32'h40);
    peek(A_DAT, r); chk("R9 srst keeps generator", r, model);

    // hardware reset mid-operation R8 R9
    wr(A_CTL, 32'h70);
    wr(A_CMD, 32'h3);
    cyc(4);
    rst_n = 0; cyc(1); rst_n = 1; cyc(1);
    peek(A_STS, r); chk("R8 hw reset status", r, 32'h5541);
    peek(A_CTL, r); chk("R8 hw reset control", r, 0);
    peek(A_DAT, r); chk("R9 hw reset reseeds", r, SEED);
    cyc(N + 2);
    chk("R8 hw reset no irq", {31'd0, irq}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule